// File: doc/BRIEF.md
# Immediate-Count Right Rotate Execution Slice

This block is one execution slice of a processor datapath. It rotates a general-purpose operand right by a count taken from an 8-bit immediate. The operand is 32 or 64 bits wide. The width comes from the current processor mode and the operand-width prefix bit. The count is masked to the chosen width. A 32-bit result is zero-extended into the 64-bit output, as a 32-bit register write would be.

The slice has no flag inputs or outputs, so it cannot disturb the arithmetic flags. An issue is rejected with an invalid-opcode exception when it arrives in real mode or virtual-8086 mode, or when the vector-length prefix bit is set. Every issue is registered. One cycle later it yields either a valid result or the exception strobe, never both.

Top module: `imm_rotr_unit`

## Requirements
- R1: With a 32-bit operand size, the result is the low 32 bits of the source rotated right by imm AND 0x1F, and result bits 63:32 are zero.
- R2: With `cpu_mode` = 2'b11 (64-bit mode) and `vex_w` = 1, the full 64-bit source is rotated right by imm AND 0x3F.
- R3: With `cpu_mode` = 2'b11 and `vex_w` = 0, the operand size is 32 bits (R1 applies).
- R4: With `cpu_mode` = 2'b10 (protected/compatibility mode), the operand size is 32 bits whatever the value of `vex_w`.
- R5: An issue with `vex_l` = 1 raises `out_undef` and leaves `out_valid` low, with `out_result` zero.
- R6: An issue with `cpu_mode` = 2'b00 (real mode) or 2'b01 (virtual-8086 mode) raises `out_undef`, leaves `out_valid` low and drives `out_result` to zero.
- R7: When the masked count is zero, the result equals the source exactly (zero-extended from 32 bits in the 32-bit size).
- R8: The result, `out_valid` and `out_undef` appear on the clock edge that follows the edge that samples `in_valid`. `out_valid` and `out_undef` are never high together.
- R9: In a cycle following one without `in_valid`, `out_valid` and `out_undef` are low and `out_result` is zero.
- R10: After reset, `out_valid`, `out_undef` and `out_result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Issue strobe |
| src_val | input | 64 | Source operand |
| imm_cnt | input | 8 | Immediate rotate count |
| cpu_mode | input | 2 | 00 real, 01 virtual-8086, 10 protected/compatibility, 11 64-bit |
| vex_w | input | 1 | Operand-width prefix bit |
| vex_l | input | 1 | Vector-length prefix bit; must be 0 |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | 64 | Rotated result |
| out_undef | output | 1 | Invalid-opcode exception strobe |

## Verification
Random sources are issued with full 8-bit immediates, so the count masking is exercised: the bits above the width must have no effect, and any difference between a 32-bit and a 64-bit rotate shows up. Walking single-bit and all-ones sources make a wrong rotate direction or a wrong wrap point visible. Zero counts, counts of 31, 32 and 63, and W toggled in each mode separate the width-selection rule from the masking rule. Issues with the L bit set and issues in real and virtual-8086 mode check that the exception is raised and that no result leaks out. Idle cycles between issues check that the strobes last only one cycle.

// File: rtl/imm_rotr_pkg.sv
package imm_rotr_pkg;

    typedef enum logic [1:0] {
        MODE_REAL = 2'b00,
        MODE_V86  = 2'b01,
        MODE_PROT = 2'b10,
        MODE_LONG = 2'b11
    } cpu_mode_e;

endpackage

// File: rtl/imm_rotr_decode.sv
module imm_rotr_decode
    import imm_rotr_pkg::*;
#(
    parameter int IMM_W = 8,
    parameter int CNT_W = 6
) (
    input  logic [IMM_W-1:0] imm_cnt,
    input  logic [1:0]       cpu_mode,
    input  logic             vex_w,
    input  logic             vex_l,
    output logic             wide_op,
    output logic             undef_op,
    output logic [CNT_W-1:0] eff_cnt
);

    cpu_mode_e mode;
    logic      unused_imm_hi;

    always_comb begin
        mode     = cpu_mode_e'(cpu_mode);
        // Only 64-bit mode honours the width bit
        wide_op  = (mode == MODE_LONG) && vex_w;
        undef_op = vex_l || (mode == MODE_REAL) || (mode == MODE_V86);
        if (wide_op) begin
            eff_cnt = imm_cnt[CNT_W-1:0];
        end else begin
            eff_cnt = {1'b0, imm_cnt[CNT_W-2:0]};
        end
    end

    assign unused_imm_hi = ^imm_cnt[IMM_W-1:CNT_W];

endmodule

// File: rtl/imm_rotr_core.sv
module imm_rotr_core #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic              wide_op,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] dout
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] stage [CNT_W+1];

    // Narrow operands are duplicated into both halves: rotating the doubled
    // pattern by less than HALF_W leaves a correct narrow rotate in the low half.
    assign stage[0] = wide_op ? din : {din[HALF_W-1:0], din[HALF_W-1:0]};

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stage[k+1] = cnt[k] ? {stage[k][SH-1:0], stage[k][DATA_W-1:SH]}
                                   : stage[k];
    end

    assign dout = wide_op ? stage[CNT_W]
                          : {{HALF_W{1'b0}}, stage[CNT_W][HALF_W-1:0]};

endmodule

// File: rtl/imm_rotr_unit.sv
module imm_rotr_unit #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_cnt,
    input  logic [1:0]        cpu_mode,
    input  logic              vex_w,
    input  logic              vex_l,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_undef
);

    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              vld;
        logic              undef;
        logic [DATA_W-1:0] res;
    } out_state_t;

    out_state_t        st_d, st_q;
    logic              wide_op;
    logic              undef_op;
    logic [CNT_W-1:0]  eff_cnt;
    logic [DATA_W-1:0] rot_val;

    imm_rotr_decode #(
        .IMM_W (IMM_W),
        .CNT_W (CNT_W)
    ) decode_i (
        .imm_cnt  (imm_cnt),
        .cpu_mode (cpu_mode),
        .vex_w    (vex_w),
        .vex_l    (vex_l),
        .wide_op  (wide_op),
        .undef_op (undef_op),
        .eff_cnt  (eff_cnt)
    );

    imm_rotr_core #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) core_i (
        .din     (src_val),
        .wide_op (wide_op),
        .cnt     (eff_cnt),
        .dout    (rot_val)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            if (undef_op) begin
                st_d.undef = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                st_d.res = rot_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_undef  = st_q.undef;
    assign out_result = st_q.res;

endmodule

// File: rtl/imm_rotr_chk.sv
module imm_rotr_chk #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_val,
    input logic [IMM_W-1:0]  imm_cnt,
    input logic [1:0]        cpu_mode,
    input logic              vex_w,
    input logic              vex_l,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_undef
);

    localparam int CNT_W  = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;

    logic legal_in;
    logic unused_chk_hi;

    assign legal_in      = !vex_l && cpu_mode[1];
    assign unused_chk_hi = ^imm_cnt[IMM_W-1:CNT_W];

    // R8
    excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_undef}));

    // R8
    legal_issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal_in |=> out_valid && !out_undef);

    // R5
    wide_len_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && vex_l |=> out_undef && !out_valid && out_result == '0);

    // R6
    bad_mode_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !cpu_mode[1] |=> out_undef && !out_valid && out_result == '0);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_undef && out_result == '0);

    // R4
    prot_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cpu_mode == 2'b10 |=> out_result[DATA_W-1:HALF_W] == '0);

    // R7
    zero_cnt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && legal_in && cpu_mode == 2'b11 && vex_w && imm_cnt[CNT_W-1:0] == '0
        |=> out_result == $past(src_val));

endmodule

bind imm_rotr_unit imm_rotr_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (.*);

// File: tb/imm_rotr_unit_tb_top.sv
`timescale 1ns/1ps
module imm_rotr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src_val = '0;
    logic [7:0]  imm_cnt = '0;
    logic [1:0]  cpu_mode = 2'b11;
    logic        vex_w = 1'b0;
    logic        vex_l = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_undef;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    imm_rotr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_val(src_val),
        .imm_cnt(imm_cnt), .cpu_mode(cpu_mode), .vex_w(vex_w), .vex_l(vex_l),
        .out_valid(out_valid), .out_result(out_result), .out_undef(out_undef)
    );

    function automatic logic [63:0] ref_rot(input logic [63:0] s, input logic [7:0] imm,
                                            input logic [1:0] md, input logic w);
        logic [31:0] s32;
        int y;
        if (md == 2'b11 && w) begin
            y = int'(imm & 8'h3F);
            return (y == 0) ? s : ((s >> y) | (s << (64 - y)));
        end
        s32 = s[31:0];
        y = int'(imm & 8'h1F);
        if (y == 0) return {32'h0, s32};
        return {32'h0, (s32 >> y) | (s32 << (32 - y))};
    endfunction

    function automatic string pick_tag(input logic [7:0] imm, input logic [1:0] md,
                                       input logic w, input logic l);
        if (l) return "R5";
        if (md[1] == 1'b0) return "R6";
        if ((md == 2'b11 && w && imm[5:0] == 0) || imm[4:0] == 0) return "R7";
        if (md == 2'b11) return w ? "R2" : "R3";
        return (w ? "R4" : "R1");
    endfunction

    task automatic check3(input string tag, input logic v, input logic u, input logic [63:0] r,
                          input logic ev, input logic eu, input logic [63:0] er);
        n_chk++;
        if (v !== ev || u !== eu || r !== er) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b undef=%0b result=%h, expected valid=%0b undef=%0b result=%h",
                     tag, v, u, r, ev, eu, er);
        end
    endtask

    // Issue one operation, sample the registered outputs, then check one idle cycle.
    task automatic issue(input logic [63:0] s, input logic [7:0] imm,
                         input logic [1:0] md, input logic w, input logic l);
        logic bad;
        @(negedge clk);
        in_valid = 1'b1; src_val = s; imm_cnt = imm; cpu_mode = md; vex_w = w; vex_l = l;
        @(posedge clk);
        #1;
        bad = l || (md[1] == 1'b0);
        // R8: outputs of the issue appear after exactly one edge
        check3(pick_tag(imm, md, w, l), out_valid, out_undef, out_result,
               !bad, bad, bad ? 64'h0 : ref_rot(s, imm, md, w));
        @(negedge clk);
        in_valid = 1'b0;
        src_val = ~s;
        @(posedge clk);
        #1;
        // R9: idle cycle clears everything
        check3("R9", out_valid, out_undef, out_result, 1'b0, 1'b0, 64'h0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog R8: got hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check3("R10", out_valid, out_undef, out_result, 1'b0, 1'b0, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corner cases
        issue(64'h0123_4567_89AB_CDEF, 8'h00, 2'b11, 1'b1, 1'b0); // R7 wide zero count
        issue(64'h0123_4567_89AB_CDEF, 8'h40, 2'b11, 1'b1, 1'b0); // R2 masked to zero
        issue(64'hFFFF_FFFF_8000_0001, 8'h20, 2'b10, 1'b0, 1'b0); // R1 masked to zero, R7
        issue(64'h0000_0000_0000_0001, 8'h01, 2'b11, 1'b1, 1'b0); // R2 wrap to bit 63
        issue(64'h0000_0000_0000_0001, 8'h3F, 2'b11, 1'b1, 1'b0); // R2
        issue(64'h0000_0000_0000_0001, 8'h20, 2'b11, 1'b1, 1'b0); // R2 count 32
        issue(64'hDEAD_BEEF_0000_0001, 8'h01, 2'b11, 1'b0, 1'b0); // R3 narrow wrap to bit 31
        issue(64'hDEAD_BEEF_0000_0001, 8'h1F, 2'b10, 1'b1, 1'b0); // R4 W ignored
        issue(64'hDEAD_BEEF_1234_5678, 8'hE3, 2'b10, 1'b0, 1'b0); // R1 high imm bits ignored
        issue(64'hFFFF_FFFF_FFFF_FFFF, 8'h05, 2'b11, 1'b1, 1'b1); // R5
        issue(64'hFFFF_FFFF_FFFF_FFFF, 8'h05, 2'b10, 1'b0, 1'b1); // R5
        issue(64'h1111_2222_3333_4444, 8'h04, 2'b00, 1'b0, 1'b0); // R6 real
        issue(64'h1111_2222_3333_4444, 8'h04, 2'b01, 1'b1, 1'b0); // R6 v86

        for (int i = 0; i < 64; i++) begin
            issue(64'h1 << i, 8'(i * 5), 2'b11, 1'(i % 2), 1'b0);
        end

        for (int i = 0; i < 400; i++) begin
            logic [63:0] s;
            logic [1:0]  md;
            logic        l;
            s  = {$urandom(), $urandom()};
            md = 2'($urandom_range(3, 0));
            l  = ($urandom_range(7, 0) == 0);
            if ($urandom_range(3, 0) == 0) md = 2'b11;
            issue(s, 8'($urandom()), md, 1'($urandom()), l);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule